// File: doc/BRIEF.md
# Bisection Carry-Lookahead Adder

This block adds two unsigned `WIDTH`-bit operands with no clock and no state. Each bit position first forms a generate term (both operand bits set) and a propagate term (exactly one operand bit set). A tree then combines these terms by repeatedly cutting a bit range in two. The lower piece of an n-bit range takes ceil(n/2) bits and the upper piece takes the rest. The carry entering the upper piece comes from the lower piece's group generate and propagate together with the carry entering the range.

Every sum bit is the propagate term of its position XOR the carry that the tree delivers to that position. The carry into bit 0 is fixed at zero. The carry leaving the most significant bit is dropped, so the result wraps modulo 2^WIDTH. The logic depth grows with log2(WIDTH) rather than with WIDTH. The block suits wide accumulations, address arithmetic, or the final carry-propagate stage after a carry-save reduction.

Top module: `cla_bisect_adder`

## Requirements
- R1: For every operand pair, `sum` equals `(a + b) mod 2^WIDTH`.
- R2: The carry into bit 0 is zero: `0 + 0` gives 0, and `x + 0` gives `x` for any `x`.
- R3: The carry out of bit `WIDTH-1` is dropped. All-ones plus one gives 0, and all-ones plus all-ones gives `2^WIDTH - 2`.
- R4: Sum bit i equals `a[i] ^ b[i] ^ c[i]`, where `c[i]` is the carry out of adding bits `i-1..0`. Adding 1 to an operand whose low k bits are all set yields `2^k` when bit k of that operand is clear.
- R5: The group propagate of any range is true exactly when every bit of that range has `a ^ b = 1`. Complementary operands therefore give an all-ones sum with no carry anywhere.
- R6: For any range, the group generate and the group propagate are never both true.
- R7: For any range, the carry leaving its top bit equals group generate OR (group propagate AND the carry entering the range).
- R8: R1 holds for odd widths, where the lower piece of a range is one bit wider than the upper piece (checked exhaustively at widths 5 and 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, unsigned |
| b | input | WIDTH | Second operand, unsigned |
| sum | output | WIDTH | Low WIDTH bits of a + b |

## Verification
Exhaustive sweeps at widths 5 and 7 cover every carry pattern through uneven bisection splits. They separate a wrong split point or a misrouted upper-piece carry from a correct tree. At width 32, random pairs exercise ordinary mixed generate/propagate ranges. Directed vectors isolate specific cases:
- all-ones plus one drives the longest carry chain across every tree level and shows the top carry is dropped;
- complementary operands hold every range in pure propagate with no carry;
- low-k-ones plus one tests whether each individual carry position is fed by the right group.

// File: rtl/cla_pkg.sv
`timescale 1ns/1ps
package cla_pkg;

    // Width of the lower piece when a range of n bits is cut in two.
    function automatic int lower_span(input int n);
        return (n + 1) / 2;
    endfunction

    // Upper piece takes whatever the lower piece leaves.
    function automatic int upper_span(input int n);
        return n - ((n + 1) / 2);
    endfunction

endpackage

// File: rtl/cla_pg_cell.sv
`timescale 1ns/1ps
module cla_pg_cell #(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] gen,
    output logic [W-1:0] prop
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign gen[i]  = op_a[i] & op_b[i];
        assign prop[i] = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/cla_node.sv
`timescale 1ns/1ps
module cla_node #(
    parameter int W = 8
) (
    input  logic [W-1:0] gen,
    input  logic [W-1:0] prop,
    input  logic         cin,
    output logic [W-1:0] carry,
    output logic         grp_g,
    output logic         grp_p
);
    if (W == 1) begin : g_leaf
        // Single bit: its carry is the range carry-in itself.
        assign carry[0] = cin;
        assign grp_g    = gen[0];
        assign grp_p    = prop[0];
    end else begin : g_split
        localparam int LO = cla_pkg::lower_span(W);
        localparam int HI = cla_pkg::upper_span(W);

        logic lo_g, lo_p, hi_g, hi_p, hi_cin;
        logic top_cout;

        cla_node #(.W(LO)) u_lo (
            .gen   (gen[LO-1:0]),
            .prop  (prop[LO-1:0]),
            .cin   (cin),
            .carry (carry[LO-1:0]),
            .grp_g (lo_g),
            .grp_p (lo_p)
        );

        // Upper piece carry-in evaluated from the lower group terms.
        assign hi_cin = lo_g | (lo_p & cin);

        cla_node #(.W(HI)) u_hi (
            .gen   (gen[W-1:LO]),
            .prop  (prop[W-1:LO]),
            .cin   (hi_cin),
            .carry (carry[W-1:LO]),
            .grp_g (hi_g),
            .grp_p (hi_p)
        );

        assign grp_g = hi_g | (lo_g & hi_p);
        assign grp_p = lo_p & hi_p;

        // Carry leaving the top bit, rippled from the delivered carry.
        assign top_cout = gen[W-1] | (prop[W-1] & carry[W-1]);

        always_comb begin
            // R5: merged propagate agrees with a flat AND of bit propagates
            assert_group_prop_R5: assert (grp_p == (&prop))
                else $error("group propagate mismatch");
            // R6: a range never both generates and propagates
            assert_group_exclusive_R6: assert (!(grp_g && grp_p))
                else $error("generate and propagate both set");
            // R7: group carry-out agrees with top-bit carry
            assert_group_cout_R7: assert ((grp_g | (grp_p & cin)) == top_cout)
                else $error("group carry-out mismatch");
        end
    end
endmodule

// File: rtl/cla_sum_row.sv
`timescale 1ns/1ps
module cla_sum_row #(
    parameter int W = 8
) (
    input  logic [W-1:0] prop,
    input  logic [W-1:0] carry,
    output logic [W-1:0] sum
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i] = prop[i] ^ carry[i];
    end
endmodule

// File: rtl/cla_bisect_adder.sv
`timescale 1ns/1ps
module cla_bisect_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] sum
);
    localparam int XW = WIDTH + 1;

    logic [WIDTH-1:0] gen, prop, carry;
    logic             root_g, root_p;
    logic [XW-1:0]    wide_ref;

    cla_pg_cell #(.W(WIDTH)) u_pg (
        .op_a (a),
        .op_b (b),
        .gen  (gen),
        .prop (prop)
    );

    cla_node #(.W(WIDTH)) u_tree (
        .gen   (gen),
        .prop  (prop),
        .cin   (1'b0),
        .carry (carry),
        .grp_g (root_g),
        .grp_p (root_p)
    );

    cla_sum_row #(.W(WIDTH)) u_sum (
        .prop  (prop),
        .carry (carry),
        .sum   (sum)
    );

    assign wide_ref = XW'(a) + XW'(b);

    always_comb begin
        // R1: result equals truncated behavioural sum
        assert_sum_matches_R1: assert (sum == wide_ref[WIDTH-1:0])
            else $error("sum mismatch");
        // R4: delivered carries equal carries of the behavioural sum
        assert_carry_vector_R4: assert (carry == (wide_ref[WIDTH-1:0] ^ a ^ b))
            else $error("carry vector mismatch");
        // R3: dropped top carry is the one the root group would produce
        assert_top_carry_R3: assert ((root_g | (root_p & 1'b0)) == wide_ref[WIDTH])
            else $error("root carry mismatch");
    end
endmodule

// File: tb/sim_cla_bisect_adder.sv
`timescale 1ns/1ps
module sim_cla_bisect_adder;

    logic clk = 1'b0;
    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [31:0] a32 = '0, b32 = '0, s32;
    logic [4:0]  a5  = '0, b5  = '0, s5;
    logic [6:0]  a7  = '0, b7  = '0, s7;

    cla_bisect_adder #(.WIDTH(32)) u0 (.a(a32), .b(b32), .sum(s32));
    cla_bisect_adder #(.WIDTH(5))  u1 (.a(a5),  .b(b5),  .sum(s5));
    cla_bisect_adder #(.WIDTH(7))  u2 (.a(a7),  .b(b7),  .sum(s7));

    function automatic logic [63:0] exp_add(input int w, input logic [63:0] x, input logic [63:0] y);
        logic [63:0] mask;
        mask = (64'd1 << w) - 64'd1;
        return (x + y) & mask;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic try32(input string req, input logic [31:0] x, input logic [31:0] y);
        a32 = x; b32 = y;
        #0.5;
        chk(req, 64'(s32), exp_add(32, 64'(x), 64'(y)));
        #0.5;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #0.25;

        // R2: zero plus zero, and identity with zero
        try32("R2 zero", 32'h0, 32'h0);
        chk("R2 zero literal", 64'(s32), 64'h0);
        try32("R2 identity", 32'hDEAD_BEEF, 32'h0);
        try32("R2 identity swap", 32'h0, 32'h1234_5678);

        // R3: top carry dropped
        try32("R3 ones plus one", 32'hFFFF_FFFF, 32'h1);
        chk("R3 wrap literal", 64'(s32), 64'h0);
        try32("R3 ones plus ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        chk("R3 max literal", 64'(s32), 64'hFFFF_FFFE);
        try32("R3 half wrap", 32'h8000_0000, 32'h8000_0000);

        // R4: each carry position fed from its own lower bits
        for (int k = 0; k < 32; k++) begin
            logic [31:0] ones;
            ones = (k == 0) ? 32'h0 : (32'hFFFF_FFFF >> (32 - k));
            try32("R4 chain", ones, 32'h1);
            chk("R4 chain literal", 64'(s32), 64'd1 << k);
        end

        // R5: complementary operands, pure propagate
        try32("R5 alternate", 32'h5555_5555, 32'hAAAA_AAAA);
        chk("R5 ones literal", 64'(s32), 64'hFFFF_FFFF);
        for (int n = 0; n < 50; n++) begin
            logic [31:0] r;
            r = $urandom;
            try32("R5 complement", r, ~r);
        end

        // R6 / R7: ranges that generate at a boundary then propagate
        try32("R7 boundary", 32'h0000_FFFF, 32'h0000_0001);
        try32("R7 cross", 32'h7FFF_8000, 32'h0000_8000);
        try32("R6 mixed", 32'h0F0F_F0F0, 32'hF0F0_F0F0);

        // R1: random pairs, plus long-chain biased pairs
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] x, y;
            x = $urandom;
            y = $urandom;
            if ((n % 4) == 3) y = ~x ^ (32'h1 << ($urandom % 32));
            try32("R1 random", x, y);
        end

        // R8: exhaustive at odd widths
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 32; j++) begin
                a5 = 5'(i); b5 = 5'(j);
                #0.5;
                chk("R8 width5", 64'(s5), exp_add(5, 64'(i), 64'(j)));
                #0.5;
            end
        end
        for (int i = 0; i < 128; i++) begin
            for (int j = 0; j < 128; j++) begin
                a7 = 7'(i); b7 = 7'(j);
                #0.5;
                chk("R8 width7", 64'(s7), exp_add(7, 64'(i), 64'(j)));
                #0.5;
            end
        end

        done = 1'b1;
        summary();
    end

endmodule